// File: doc/BRIEF.md
# Digital Phase-Frequency Comparator with Lock Monitor

This block compares a reference pulse train against a divided feedback pulse train, both sampled on a fast system clock. It works out which train's rising edge came first and turns that into charge-pump steering: a pump-up request, a pump-down request and a drive enable for a tri-state pump pin. It also drives a pair of comparator outputs for an external pump. The first is a push-pull level. The second is an open-drain pull-down that is either driving low or released.

A polarity input reverses the sense of the comparison, so the block can suit a VCO whose tuning slope is negative. A lock monitor measures, in system-clock cycles, how long each one-sided error pulse lasts. It declares loss of lock at once when a pulse grows too wide, and it declares lock again only after a run of consecutive narrow comparisons. A single monitor pin carries either the lock flag or a copy of the reference or feedback train.

Two further inputs override the pump. A drive-enable input releases the pump pin while the comparator keeps running. A run input, held low, puts the block in power save: the comparator stays idle and the lock flag is forced high.

Top module: `pfd_lock_top`

## Requirements
- R1: After reset, pump_up, pump_dn, pump_oe, cmp_r, cmp_p_pull and lock_o are all 0.
- R2: With pol_pos=1, a reference rise that leads the feedback rise by D cycles drives pump_up for D+1 cycles and pump_dn for 1 cycle, the last cycle of the pump_up pulse. A feedback lead gives the mirror image.
- R3: With pol_pos=0, the roles of pump_up and pump_dn in R2 are exchanged.
- R4: Rises on both trains in the same cycle give a single cycle with pump_up and pump_dn both at 1. Every comparison ends with exactly one such overlap cycle.
- R5: pump_oe is 1 exactly when pump_up or pump_dn is 1. With neither active it is 0.
- R6: Outside an overlap cycle, with pol_pos=1, a reference lead sets cmp_p_pull=1 (pull low) and cmp_r=0. A feedback lead sets cmp_r=1 and cmp_p_pull=0 (released). With pol_pos=0, these two cases swap. When neither train leads, both outputs are 0.
- R7: With mon_sel=1, mon_out follows the reference input when pol_pos=1 and the feedback input when pol_pos=0, one clock after the input. With mon_sel=0, mon_out equals lock_o.
- R8: lock_o falls on the clock edge at which a one-sided error pulse reaches UNLOCK_CNT cycles (default 4), while the pulse is still active. A pulse of UNLOCK_CNT-1 cycles leaves lock_o unchanged.
- R9: lock_o rises only after GOOD_RUN consecutive comparisons (default 3) whose error is at most LOCK_CNT cycles (default 2). A comparison with a larger error restarts the run.
- R10: With drive_en=0, pump_up, pump_dn and pump_oe are 0, while cmp_r and cmp_p_pull keep following the comparison.
- R11: With run=0, pump outputs and comparator outputs stay 0 and lock_o is 1 from the next clock. lock_o stays 1 after run returns high until an unlock event occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample both trains and to measure the error |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference pulse train, synchronous to clk |
| fb_in | input | 1 | Divided feedback pulse train, synchronous to clk |
| pol_pos | input | 1 | Comparison polarity (1 = positive slope) |
| mon_sel | input | 1 | Monitor select: 1 = pulse train, 0 = lock flag |
| drive_en | input | 1 | 0 releases the pump pin |
| run | input | 1 | 0 = power save |
| pump_up | output | 1 | Pump drives high |
| pump_dn | output | 1 | Pump drives low |
| pump_oe | output | 1 | Pump pin drive enable |
| cmp_r | output | 1 | Push-pull comparator output |
| cmp_p_pull | output | 1 | Open-drain comparator output: 1 pulls low, 0 released |
| mon_out | output | 1 | Monitor output |
| lock_o | output | 1 | Lock flag |

## Verification
The bench targets the lock thresholds at their edges. An error of exactly LOCK_CNT must still count towards lock, and an error of UNLOCK_CNT-1 must neither unlock nor count. A design with an off-by-one in either comparison would lock a comparison early or drop lock on a pulse that should be tolerated. The bench checks that the unlock happens while the error pulse is still active, so a detector that only decides at the end of a comparison is caught. It also checks that a bad comparison restarts the good run instead of pausing it, and that zero error still gives the one-cycle overlap pulse. The overrides are exercised as well: under drive_en=0 the comparator outputs must keep moving while the pump stays silent, and after power save the forced lock flag must persist.

// File: rtl/pfd_pkg.sv
// Shared types for the phase-frequency comparator.
// Assumes nothing beyond a single clock domain.
package pfd_pkg;

    // Raw comparator request: up = reference leads, dn = feedback leads.
    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;

    // Apply the comparison polarity: negative polarity swaps up and down.
    function automatic pump_req_t orient(pump_req_t r, logic pos);
        pump_req_t o;
        o.up = pos ? r.up : r.dn;
        o.dn = pos ? r.dn : r.up;
        return o;
    endfunction

endpackage

// File: rtl/pfd_edge_core.sv
// Samples the reference and feedback trains, detects rising edges and
// keeps the two request flags of a phase-frequency comparator.
// Assumes both trains are synchronous to clk. When both flags are set, they
// clear together on the next edge (one-cycle overlap pulse).
module pfd_edge_core
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_in,
    input  logic      fb_in,
    input  logic      run,
    output logic      ref_s,
    output logic      fb_s,
    output pump_req_t req,
    output logic      done
);

    logic ref_d, fb_d;
    logic ref_rise, fb_rise;

    // Sample both trains and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_s <= 1'b0;
            ref_d <= 1'b0;
            fb_s  <= 1'b0;
            fb_d  <= 1'b0;
        end else begin
            ref_s <= ref_in;
            ref_d <= ref_s;
            fb_s  <= fb_in;
            fb_d  <= fb_s;
        end
    end

    assign ref_rise = ref_s & ~ref_d;
    assign fb_rise  = fb_s  & ~fb_d;
    assign done     = req.up & req.dn;

    // Set a flag on its train's rising edge; clear both once both are set.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) begin
            req <= '0;
        end else begin
            req.up <= req.up | ref_rise;
            req.dn <= req.dn | fb_rise;
        end
    end

endmodule

// File: rtl/pfd_lock_det.sv
// Lock monitor: measures the width of each one-sided error pulse in clk
// cycles. Drops lock as soon as the width reaches UNLOCK_CNT. Raises lock
// after GOOD_RUN consecutive comparisons with width <= LOCK_CNT.
// Assumes LOCK_CNT < UNLOCK_CNT and GOOD_RUN >= 1.
module pfd_lock_det #(
    parameter int UNLOCK_CNT = 4,
    parameter int LOCK_CNT   = 2,
    parameter int GOOD_RUN   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic single,
    input  logic done,
    output logic lock
);

    localparam int ERR_W  = $clog2(UNLOCK_CNT + 2);
    localparam int GOOD_W = $clog2(GOOD_RUN + 1);

    logic [ERR_W-1:0]  err;
    logic [ERR_W-1:0]  err_nxt;
    logic [GOOD_W-1:0] good;
    logic              too_wide;

    assign err_nxt  = err + ERR_W'(1);
    assign too_wide = single && (err_nxt >= ERR_W'(UNLOCK_CNT));

    // Count the cycles of the current one-sided pulse, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || done) begin
            err <= '0;
        end else if (single && err != ERR_W'(UNLOCK_CNT)) begin
            err <= err_nxt;
        end
    end

    // Track the run of narrow comparisons and update the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b0;
            good <= '0;
        end else if (!run) begin
            lock <= 1'b1;
            good <= '0;
        end else if (too_wide) begin
            lock <= 1'b0;
            good <= '0;
        end else if (done) begin
            if (err <= ERR_W'(LOCK_CNT)) begin
                if (good == GOOD_W'(GOOD_RUN - 1)) lock <= 1'b1;
                if (good != GOOD_W'(GOOD_RUN))     good <= good + GOOD_W'(1);
            end else begin
                good <= '0;
            end
        end
    end

endmodule

// File: rtl/pfd_out_map.sv
// Output mapping: applies polarity, the drive and power-save gates, the
// comparator-pair encoding and the monitor select. Purely combinational.
module pfd_out_map
    import pfd_pkg::*;
(
    input  pump_req_t req,
    input  logic      pol_pos,
    input  logic      drive_en,
    input  logic      run,
    input  logic      mon_sel,
    input  logic      ref_s,
    input  logic      fb_s,
    input  logic      lock,
    output logic      pump_up,
    output logic      pump_dn,
    output logic      pump_oe,
    output logic      cmp_r,
    output logic      cmp_p_pull,
    output logic      mon_out
);

    pump_req_t ori;
    logic      lead_only, lag_only, gate;

    // Pump steering with polarity, then the release and power-save gates.
    always_comb begin
        ori       = orient(req, pol_pos);
        gate      = drive_en & run;
        pump_up   = gate & ori.up;
        pump_dn   = gate & ori.dn;
        pump_oe   = pump_up | pump_dn;
    end

    // Comparator pair: one-sided leads only; overlap and idle leave both off.
    always_comb begin
        lead_only  = req.up & ~req.dn;
        lag_only   = req.dn & ~req.up;
        cmp_r      = pol_pos ? lag_only  : lead_only;
        cmp_p_pull = pol_pos ? lead_only : lag_only;
    end

    // Monitor pin: a sampled pulse train or the lock flag.
    always_comb begin
        mon_out = mon_sel ? (pol_pos ? ref_s : fb_s) : lock;
    end

endmodule

// File: rtl/pfd_lock_top.sv
// Top level of the phase-frequency comparator with lock monitor.
// Assumes ref_in and fb_in are synchronous to clk and their high and low
// phases each last at least two clk cycles.
module pfd_lock_top
    import pfd_pkg::*;
#(
    parameter int UNLOCK_CNT = 4,
    parameter int LOCK_CNT   = 2,
    parameter int GOOD_RUN   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic pol_pos,
    input  logic mon_sel,
    input  logic drive_en,
    input  logic run,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_oe,
    output logic cmp_r,
    output logic cmp_p_pull,
    output logic mon_out,
    output logic lock_o
);

    pump_req_t req;
    logic      ref_s, fb_s, done, lock;

    pfd_edge_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_in (ref_in),
        .fb_in  (fb_in),
        .run    (run),
        .ref_s  (ref_s),
        .fb_s   (fb_s),
        .req    (req),
        .done   (done)
    );

    pfd_lock_det #(
        .UNLOCK_CNT (UNLOCK_CNT),
        .LOCK_CNT   (LOCK_CNT),
        .GOOD_RUN   (GOOD_RUN)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .single (req.up ^ req.dn),
        .done   (done),
        .lock   (lock)
    );

    pfd_out_map u_map (
        .req        (req),
        .pol_pos    (pol_pos),
        .drive_en   (drive_en),
        .run        (run),
        .mon_sel    (mon_sel),
        .ref_s      (ref_s),
        .fb_s       (fb_s),
        .lock       (lock),
        .pump_up    (pump_up),
        .pump_dn    (pump_dn),
        .pump_oe    (pump_oe),
        .cmp_r      (cmp_r),
        .cmp_p_pull (cmp_p_pull),
        .mon_out    (mon_out)
    );

    assign lock_o = lock;

endmodule

// File: rtl/pfd_lock_checker.sv
// Assertion checker for pfd_lock_top, attached by bind below.
module pfd_lock_checker (
    input logic clk,
    input logic rst_n,
    input logic drive_en,
    input logic run,
    input logic pump_up,
    input logic pump_dn,
    input logic pump_oe,
    input logic cmp_r,
    input logic cmp_p_pull,
    input logic lock_o
);

    // R5: the pin is driven only while a pump request is active
    p_oe_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pump_oe |-> (pump_up || pump_dn));

    // R4: an overlap pulse never lasts more than one cycle
    p_overlap_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && pump_dn) |=> !(pump_up && pump_dn));

    // R6: the comparator pair never pulls both ways at once
    p_cmp_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_r && cmp_p_pull));

    // R10: released pump pin carries no request
    p_release_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (!pump_oe && !pump_up && !pump_dn));

    // R11: power save silences the pump and forces the lock flag
    p_save_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pump_oe);

    p_save_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> lock_o);

    // R11: in power save the comparator outputs stay idle on the next cycle
    p_save_cmp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> (!cmp_r && !cmp_p_pull));

endmodule

bind pfd_lock_top pfd_lock_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drive_en   (drive_en),
    .run        (run),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn),
    .pump_oe    (pump_oe),
    .cmp_r      (cmp_r),
    .cmp_p_pull (cmp_p_pull),
    .lock_o     (lock_o)
);

// File: tb/pfd_lock_top_test.sv
module pfd_lock_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 16;
    localparam int NVEC       = 8;
    // pol, lead (+ = reference first), pump_up cycles, pump_dn cycles,
    // cmp_r cycles, cmp_p_pull cycles
    localparam int VEC [NVEC][6] = '{
        '{1,  2, 3, 1, 0, 2},
        '{1, -3, 1, 4, 3, 0},
        '{1,  0, 1, 1, 0, 0},
        '{0,  2, 1, 3, 2, 0},
        '{0, -1, 2, 1, 0, 1},
        '{0,  0, 1, 1, 0, 0},
        '{1,  5, 6, 1, 0, 5},
        '{1, -1, 1, 2, 1, 0}
    };

    logic clk = 1'b0;
    logic rst_n, ref_in, fb_in, pol_pos, mon_sel, drive_en, run;
    logic pump_up, pump_dn, pump_oe, cmp_r, cmp_p_pull, mon_out, lock_o;
    int   nchk = 0;
    int   nfail = 0;
    bit   finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_lock_top uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .pol_pos(pol_pos), .mon_sel(mon_sel), .drive_en(drive_en), .run(run),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_oe(pump_oe),
        .cmp_r(cmp_r), .cmp_p_pull(cmp_p_pull), .mon_out(mon_out),
        .lock_o(lock_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // One comparison: drive both rises, count active output cycles.
    task automatic do_cmp(input int lead, output int nu, output int nd,
                          output int nr, output int np, output int noe_bad);
        int ta, tb;
        ta = (lead < 0) ? -lead : 0;
        tb = (lead > 0) ?  lead : 0;
        nu = 0; nd = 0; nr = 0; np = 0; noe_bad = 0;
        for (int t = 0; t < WIN; t++) begin
            @(negedge clk);
            ref_in = (t >= ta);
            fb_in  = (t >= tb);
            nu += int'(pump_up);
            nd += int'(pump_dn);
            nr += int'(cmp_r);
            np += int'(cmp_p_pull);
            if (pump_oe != (pump_up | pump_dn)) noe_bad++;
        end
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int nu, nd, nr, np, nb;
        rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
        pol_pos = 1'b1; mon_sel = 1'b0; drive_en = 1'b1; run = 1'b1;
        do_reset();

        // R1: reset state
        chk("R1 outputs", {pump_up, pump_dn, pump_oe, cmp_r, cmp_p_pull, lock_o}, 0);

        // R2 R3 R4 R5 R6: table of comparisons
        for (int i = 0; i < NVEC; i++) begin
            pol_pos = (VEC[i][0] != 0);
            do_cmp(VEC[i][1], nu, nd, nr, np, nb);
            chk($sformatf("R2/R3/R4 pump_up vec%0d", i), nu, VEC[i][2]);
            chk($sformatf("R2/R3/R4 pump_dn vec%0d", i), nd, VEC[i][3]);
            chk($sformatf("R6 cmp_r vec%0d", i), nr, VEC[i][4]);
            chk($sformatf("R6 cmp_p_pull vec%0d", i), np, VEC[i][5]);
            chk($sformatf("R5 pump_oe vec%0d", i), nb, 0);
        end

        // R7: monitor select
        mon_sel = 1'b1; pol_pos = 1'b1;
        @(negedge clk); ref_in = 1'b1; fb_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 mon shows reference", mon_out, 1);
        pol_pos = 1'b0; #1;
        chk("R7 mon shows feedback", mon_out, 0);
        mon_sel = 1'b0; #1;
        chk("R7 mon shows lock", mon_out, lock_o);
        @(negedge clk); fb_in = 1'b1;
        repeat (3) @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (4) @(negedge clk);
        pol_pos = 1'b1;

        // R9: lock acquisition and restart of the good run
        do_reset();
        do_cmp(0, nu, nd, nr, np, nb);
        do_cmp(1, nu, nd, nr, np, nb);
        chk("R9 two good comparisons", lock_o, 0);
        do_cmp(3, nu, nd, nr, np, nb);
        do_cmp(0, nu, nd, nr, np, nb);
        do_cmp(-2, nu, nd, nr, np, nb);
        chk("R9 run restarted by wide error", lock_o, 0);
        do_cmp(2, nu, nd, nr, np, nb);
        chk("R9 lock after third good", lock_o, 1);

        // R8: width UNLOCK_CNT-1 keeps lock
        do_cmp(-3, nu, nd, nr, np, nb);
        chk("R8 error 3 keeps lock", lock_o, 1);

        // R8: unlock while the pulse is still active
        @(negedge clk); ref_in = 1'b1;
        repeat (5) @(negedge clk);
        chk("R8 not yet unlocked", lock_o, 1);
        repeat (2) @(negedge clk);
        chk("R8 unlocked mid pulse", lock_o, 0);
        chk("R8 pump still active", pump_up, 1);
        fb_in = 1'b1;
        repeat (4) @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (4) @(negedge clk);

        // R10: released pump, comparator still running
        drive_en = 1'b0;
        do_cmp(2, nu, nd, nr, np, nb);
        chk("R10 pump_up silent", nu, 0);
        chk("R10 pump_dn silent", nd, 0);
        chk("R10 cmp_p_pull still active", np, 2);
        chk("R10 pump_oe silent", nb, 0);
        drive_en = 1'b1;

        // R11: power save
        run = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 lock forced high", lock_o, 1);
        do_cmp(3, nu, nd, nr, np, nb);
        chk("R11 pump silent", nu + nd, 0);
        chk("R11 comparator idle", nr + np, 0);
        run = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 lock held after exit", lock_o, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule